// File: doc/BRIEF.md
# Two-Partition Shared Cache Router

This block steers requests from two groups of cores into a second-level cache that is split into two partitions. Each core group is wired straight to one partition, its near side. It reaches the other partition, its far side, over a slower fabric. Memory is cut into 8 KB pages, and every page has exactly one home partition, chosen by the lowest address bit above the page offset. For each accepted request the router names the partition that serves it, flags whether the far path is taken, and charges the far path a fixed extra delay.

Placement is decided per request. A strong load, or a load from the home group, installs its line in the home partition only. An ordinary load from the other group, to a line that has no copy yet, is served from home. It also places a replica in the requester's near partition, so that later loads from that group stay near. A small direct-mapped replica directory tracks these copies. A write is always served by the home partition. If the line has a replica, the write first sends an invalidate to the other partition and then acknowledges, which keeps the two partitions coherent.

Requests enter through a valid/ready handshake, one per cycle at most. Results leave in acceptance order.

Top module: `l2_part_router`

## Requirements
- R1: After reset, out_valid and inv_valid are low, req_ready is high, and the directory holds no replica.
- R2: The home partition of an address is its bit 13. Writes and strong loads are always served by the home partition.
- R3: A request served by the requester's own partition (out_part equal to req_grp) has out_far=0 and appears on the output in the cycle after acceptance.
- R4: A request served by the other partition has out_far=1 and appears exactly 8 cycles later than a near request would.
- R5: A non-strong load from the non-home group, to a line with no replica and a free directory slot, is served by home with out_repl=1. Later non-strong loads from that group to the same line are served near by the requester's partition with out_repl=0.
- R6: A strong load (req_strong=1) never sets out_repl and never reads a replica.
- R7: A load from the home group is served near by home with out_repl=0 and leaves the directory unchanged.
- R8: A write to a line with a replica raises inv_valid in the cycle after acceptance. inv_part is the non-home partition and inv_addr is the line address with its low 7 bits zero. The write acknowledge comes one cycle later than it would without the invalidate, and the replica is dropped.
- R9: A write to a line without a replica raises no invalidate and takes no extra cycle.
- R10: The directory slot is address bits [10:7]. A load whose slot holds a different line does not replicate and is served far by home.
- R11: req_ready is low only while an accepted request is still waiting for its result. Outputs appear in acceptance order, carrying the request's address and write flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Router can take a request |
| req_addr | input | 32 | Byte address |
| req_grp | input | 1 | Core group issuing the request (0 or 1) |
| req_write | input | 1 | 1 = write, 0 = load |
| req_strong | input | 1 | Load must allocate in home partition only |
| out_valid | output | 1 | Routed result / acknowledge present |
| out_addr | output | 32 | Address of the routed request |
| out_write | output | 1 | Routed request was a write |
| out_part | output | 1 | Partition that served the request |
| out_far | output | 1 | Served across the far fabric |
| out_repl | output | 1 | Fill also installed in requester's near partition |
| inv_valid | output | 1 | Invalidate of a replica issued |
| inv_addr | output | 32 | Line address being invalidated |
| inv_part | output | 1 | Partition holding the replica |

## Verification
Directed traffic first walks one line through the full life of a replica. It loads the line from its home group, loads it from the far group to create a replica, loads it again to hit near, writes it to invalidate the copy, and loads it once more to rebuild the copy. These steps separate the near, far and replica-hit routes and expose a missing invalidate. Strong loads to a line that has a live replica tell the strong and ordinary placement rules apart. A second line mapping to the same directory slot checks that a conflict suppresses replication rather than silently overwriting the tracked copy. Random traffic then mixes back-to-back requests, idle gaps, stalls behind far requests and both groups over a few lines in few slots. Under this mix the cycle-exact ready, output and invalidate timing is compared against a behavioural model on every clock.

// File: rtl/l2_part_router.sv
module l2_part_router #(
  parameter int AW        = 32,
  parameter int LINE_BITS = 7,
  parameter int PAGE_BIT  = 13,
  parameter int DIR_BITS  = 4,
  parameter int FAR_DELAY = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_grp,
  input  logic          req_write,
  input  logic          req_strong,
  output logic          out_valid,
  output logic [AW-1:0] out_addr,
  output logic          out_write,
  output logic          out_part,
  output logic          out_far,
  output logic          out_repl,
  output logic          inv_valid,
  output logic [AW-1:0] inv_addr,
  output logic          inv_part
);
  localparam int DEPTH = 1 << DIR_BITS;
  localparam int TW    = AW - LINE_BITS - DIR_BITS;
  localparam int CW    = $clog2(FAR_DELAY + 2);

  logic [DEPTH-1:0] dir_v;
  logic [TW-1:0]    dir_tag [DEPTH];
  logic             full;
  logic [CW-1:0]    cnt;

  wire                home   = req_addr[PAGE_BIT];
  wire [DIR_BITS-1:0] idx    = req_addr[LINE_BITS +: DIR_BITS];
  wire [TW-1:0]       tag    = req_addr[AW-1 -: TW];
  wire                rep    = dir_v[idx] && dir_tag[idx] == tag;
  wire                away   = req_grp != home;
  wire                ld_any = !req_write && !req_strong && away;
  wire                use_rep = ld_any && rep;
  wire                do_rep  = ld_any && !dir_v[idx];
  wire                do_inv  = req_write && rep;
  wire                serve   = use_rep ? req_grp : home;
  wire                far     = serve != req_grp;
  wire                accept  = req_valid && req_ready;
  wire [CW-1:0]       lat     = (far ? CW'(FAR_DELAY) : '0) + CW'(do_inv);

  assign out_valid = full && cnt == '0;
  assign req_ready = !full || cnt == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full      <= 1'b0;
      cnt       <= '0;
      out_addr  <= '0;
      out_write <= 1'b0;
      out_part  <= 1'b0;
      out_far   <= 1'b0;
      out_repl  <= 1'b0;
      inv_valid <= 1'b0;
      inv_addr  <= '0;
      inv_part  <= 1'b0;
      dir_v     <= '0;
      for (int i = 0; i < DEPTH; i++) dir_tag[i] <= '0;
    end else begin
      inv_valid <= accept && do_inv;
      if (accept) begin
        full      <= 1'b1;
        cnt       <= lat;
        out_addr  <= req_addr;
        out_write <= req_write;
        out_part  <= serve;
        out_far   <= far;
        out_repl  <= do_rep;
        inv_addr  <= {req_addr[AW-1:LINE_BITS], {LINE_BITS{1'b0}}};
        inv_part  <= ~home;
        if (do_rep) begin
          dir_v[idx]   <= 1'b1;
          dir_tag[idx] <= tag;
        end
        if (do_inv) dir_v[idx] <= 1'b0;
      end else if (full && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else if (full) begin
        full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/l2_part_router_chk.sv
module l2_part_router_chk #(
  parameter int AW       = 32,
  parameter int PAGE_BIT = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          out_valid,
  input logic [AW-1:0] out_addr,
  input logic          out_write,
  input logic          out_part,
  input logic          out_far,
  input logic          out_repl,
  input logic          inv_valid,
  input logic [AW-1:0] inv_addr,
  input logic          inv_part
);
  AST_WRITE_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_write |-> out_part == out_addr[PAGE_BIT]); // R2
  AST_REPL_FROM_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_repl |-> out_far && !out_write && out_part == out_addr[PAGE_BIT]); // R5
  AST_INV_BEFORE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> !out_valid); // R8
  AST_INV_NOT_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> inv_part != inv_addr[PAGE_BIT]); // R8
  AST_READY_ON_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> req_ready); // R11
endmodule

bind l2_part_router l2_part_router_chk #(.AW(AW), .PAGE_BIT(PAGE_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .out_valid(out_valid),
  .out_addr(out_addr), .out_write(out_write), .out_part(out_part),
  .out_far(out_far), .out_repl(out_repl), .inv_valid(inv_valid),
  .inv_addr(inv_addr), .inv_part(inv_part));

// File: tb/l2_part_router_bench.sv
`timescale 1ns/1ps
module l2_part_router_bench;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_grp = 0, req_write = 0, req_strong = 0;
  logic [31:0] req_addr = 0;
  logic req_ready, out_valid, out_write, out_part, out_far, out_repl, inv_valid, inv_part;
  logic [31:0] out_addr, inv_addr;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  l2_part_router u_l2_part_router (.*);

  // reference model state
  logic [24:0] mdir [int];
  int last_out = 0, p_cyc = -1, i_cyc = -1;
  logic [31:0] p_addr, i_addr;
  logic p_wr, p_part, p_far, p_repl, i_part;
  string p_tag;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_accept(int d, logic [31:0] a, logic g, logic w, logic s);
    logic home = a[13];
    int slot = int'(a[10:7]);
    logic [24:0] line = a[31:7];
    bit rep = mdir.exists(slot) && mdir[slot] == line;
    bit inv = 0;
    p_repl = 0; p_part = home; p_tag = "R2";
    if (w) begin
      inv = rep; p_tag = rep ? "R8" : "R9";
      if (rep) mdir.delete(slot);
    end else if (s) p_tag = "R6";
    else if (g == home) p_tag = "R7";
    else if (rep) begin p_part = g; p_tag = "R5"; end
    else if (!mdir.exists(slot)) begin p_repl = 1; mdir[slot] = line; p_tag = "R5"; end
    else p_tag = "R10";
    p_far = p_part != g; p_addr = a; p_wr = w;
    p_cyc = d + 1 + (p_far ? 8 : 0) + (inv ? 1 : 0);
    last_out = p_cyc;
    if (inv) begin i_cyc = d + 1; i_addr = {a[31:7], 7'b0}; i_part = ~home; end
  endtask

  task automatic check_cycle(int d);
    bit eo = (d == p_cyc), ei = (d == i_cyc);
    chk(req_ready == (d >= last_out), "R11", "req_ready", req_ready, d >= last_out);
    chk(out_valid == eo, p_far ? "R4" : "R3", "out_valid", out_valid, eo);
    if (eo && out_valid) begin
      chk(out_addr == p_addr && out_write == p_wr, "R11", "out_addr", out_addr, p_addr);
      chk(out_part == p_part, p_tag, "out_part", out_part, p_part);
      chk(out_far == p_far, p_far ? "R4" : "R3", "out_far", out_far, p_far);
      chk(out_repl == p_repl, p_tag, "out_repl", out_repl, p_repl);
    end
    chk(inv_valid == ei, ei ? "R8" : "R9", "inv_valid", inv_valid, ei);
    if (ei && inv_valid)
      chk(inv_addr == i_addr && inv_part == i_part, "R8", "inv_addr", inv_addr, i_addr);
  endtask

  // directed request i: returns {addr, grp, write, strong}
  function automatic logic [34:0] directed(int i);
    logic [31:0] A = 32'h0000_2080, B = 32'h0001_2080, C = 32'h0000_0100;
    case (i)
      0: return {A, 3'b100};   // R3 home group near
      1: return {A, 3'b000};   // R5 replicate
      2: return {A, 3'b000};   // R5 replica hit
      3: return {A, 3'b100};   // R7 home group
      4: return {B, 3'b000};   // R10 slot conflict
      5: return {A, 3'b001};   // R6 strong ignores replica
      6: return {A, 3'b110};   // R8 write invalidates
      7: return {A, 3'b000};   // R5 rebuild replica
      8: return {A, 3'b010};   // R8 far write + invalidate
      9: return {C, 3'b010};   // R9 write, no replica
      10: return {C, 3'b100};  // R5 replicate into group 1
      default: return {C, 3'b101}; // R6 strong from away group
    endcase
  endfunction

  initial begin
    int cyc, sent;
    bit have;
    logic [34:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!out_valid && !inv_valid, "R1", "outputs in reset", {out_valid, inv_valid}, 0);
    chk(req_ready, "R1", "ready in reset", req_ready, 1);
    rst_n = 1;
    cyc = 0; sent = 0; have = 0;
    while (sent < 412) begin
      check_cycle(cyc);
      if (!have) begin
        if (sent < 12) begin
          r = directed(sent); have = 1;
        end else if ($urandom_range(9) < 7) begin
          r[34:3] = {18'h0, 1'($urandom_range(1)), 1'b0, 1'b0, 2'($urandom_range(3)) + 2'd0, 2'b00, 2'($urandom_range(3)), 7'h0}
                    | (32'($urandom_range(1)) << 16);
          r[2] = 1'($urandom_range(1));
          r[1] = $urandom_range(3) == 0;
          r[0] = $urandom_range(4) == 0;
          have = 1;
        end
      end
      req_valid = have;
      {req_addr, req_grp, req_write, req_strong} = have ? r : 35'h0;
      if (have && cyc >= last_out) begin
        model_accept(cyc, req_addr, req_grp, req_write, req_strong);
        have = 0; sent++;
      end
      @(posedge clk);
      cyc++;
      @(negedge clk);
      req_valid = 0;
    end
    repeat (12) begin check_cycle(cyc); @(posedge clk); cyc++; @(negedge clk); end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule